// File: doc/BRIEF.md
# DMA Burst Scheduler

This block is the control core of a DMA engine. Six logical channels share one physical transfer engine, so only one channel can move data at a time. Each channel has a trigger input and is configured with a source pointer, a destination pointer, a burst length, a transfer length and a one-shot bit. The scheduler keeps a pending flag for each channel and chooses the next channel by fixed priority. It moves each word as a read from internal memory followed by a write to the external port. It decides when a different channel is allowed to take over the engine.

The external port is shared with CPU masters. After every DMA write handshake, a CPU that is requesting the port receives a grant that lasts exactly one cycle. During that cycle the engine is already reading its next word. When no CPU is requesting, the engine continues without an idle cycle. The number of CPU slots therefore depends on the number of words moved, not on the burst length.

Top module: `dma_burst_sched`

## Requirements
- R1: At most one of `rd_req` and `wr_req` is high in any cycle. Only the active channel's pointers advance.
- R2: `cfg_burst` holds the number of words per burst minus one. A value of 1 gives 2-word bursts.
- R3: `cfg_xfer` holds the number of bursts per transfer minus one. With `cfg_burst`=1 and `cfg_xfer`=79, one transfer is 160 words.
- R4: With one-shot off, a trigger moves exactly one burst. No other channel writes until that burst ends. The cycle after the last write of a burst has no read or write request, because it is the arbitration cycle.
- R5: With one-shot on, one trigger runs every remaining burst of the transfer back to back. No other channel writes until the transfer ends.
- R6: When the engine is free, the pending channel with the lowest index (0 is highest) is started next.
- R7: Triggers are latched in a pending flag per channel, which is cleared when that channel is started. The pointers and the remaining-burst count of a channel are kept while other channels run, so a later trigger resumes with the next burst.
- R8: Each word is read at the channel's source address. The read data is then written to the channel's destination address. Both pointers then increase by one.
- R9: `cpu_gnt` is high for exactly one cycle, the cycle after a DMA write handshake (`wr_req` and `wr_rdy`) in which `cpu_req` was high. It is low in every other cycle and is never high together with `wr_req`.
- R10: After a write handshake that is not the last write of an ownership period, `rd_req` is high in the next cycle, whatever `cpu_req` is.
- R11: `done[c]` pulses for one cycle, in the cycle after the final write of channel c's transfer. The channel's burst count is then reloaded, so the next trigger runs a full transfer again from the current pointers.
- R12: During and after reset, `rd_req`, `wr_req`, `cpu_gnt` and `done` are low.
- R13: A pulse on `cfg_we` loads the selected channel's burst length, transfer length, one-shot bit and both pointers, and restarts its burst count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | NCH | Trigger pulse per channel |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_ch | input | CHW | Channel selected for the load |
| cfg_burst | input | BW | Words per burst minus one |
| cfg_xfer | input | TW | Bursts per transfer minus one |
| cfg_oneshot | input | 1 | One-shot mode bit |
| cfg_src | input | AW | Start source pointer |
| cfg_dst | input | AW | Start destination pointer |
| rd_req | output | 1 | Internal-memory read request |
| rd_addr | output | AW | Read address |
| rd_rdy | input | 1 | Read completes this cycle |
| rd_data | input | DW | Read data |
| wr_req | output | 1 | External-port write request |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_rdy | input | 1 | Write completes this cycle |
| cpu_req | input | 1 | CPU wants the external port |
| cpu_gnt | output | 1 | One-cycle CPU slot on the port |
| done | output | NCH | Transfer-complete pulse per channel |

## Verification
The bench puts a higher-priority trigger in the middle of a burst and in the middle of a one-shot transfer. A scheduler that switches channels per word, or that lets a one-shot transfer be broken up, shows a foreign write inside an ownership period. The bench also runs a 160-word one-shot transfer with 2-word bursts and counts the words and the done pulses, so an off-by-one in the minus-one encodings moves the done pulse. Random `cpu_req` and ready stalls check that a grant follows every qualifying write handshake and no other cycle, and that the engine never inserts an idle cycle in the middle of a burst. A preempted channel is re-triggered later, and its pointers must continue exactly where they stopped.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } eng_state_t;

    function automatic logic [15:0] ptr_step(input logic [15:0] p);
        return p + 16'd1;
    endfunction

endpackage

// File: rtl/dma_pend_latch.sv
module dma_pend_latch #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | trig;
    end

    AST_TRIG_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (trig != '0) |=> ((pend & $past(trig)) == $past(trig))); // R7
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 6,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [BW-1:0] burst_in,
    input  logic [TW-1:0] xfer_in,
    input  logic          oneshot_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic          adv_src,
    input  logic          adv_dst,
    input  logic          burst_end,
    input  logic          xfer_end,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [BW-1:0] burst_len,
    output logic          oneshot,
    output logic          last_burst
);
    logic [TW-1:0] xfer_len;
    logic [TW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            src       <= '0;
            dst       <= '0;
            burst_len <= '0;
            xfer_len  <= '0;
            oneshot   <= 1'b0;
            rem       <= '0;
        end else if (load) begin
            src       <= src_in;
            dst       <= dst_in;
            burst_len <= burst_in;
            xfer_len  <= xfer_in;
            oneshot   <= oneshot_in;
            rem       <= xfer_in;
        end else begin
            if (adv_src)       src <= src + AW'(1);
            if (adv_dst)       dst <= dst + AW'(1);
            if (xfer_end)      rem <= xfer_len;
            else if (burst_end) rem <= rem - TW'(1);
        end
    end

    assign last_burst = (rem == '0);

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        load |=> (rem == $past(xfer_in))); // R13
endmodule

// File: rtl/dma_burst_sched.sv
module dma_burst_sched
    import dma_sched_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int BW  = 8,
    parameter int TW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [BW-1:0]  cfg_burst,
    input  logic [TW-1:0]  cfg_xfer,
    input  logic           cfg_oneshot,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_rdy,
    input  logic [DW-1:0]  rd_data,
    output logic           wr_req,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    input  logic           wr_rdy,
    input  logic           cpu_req,
    output logic           cpu_gnt,
    output logic [NCH-1:0] done
);
    eng_state_t     state;
    logic [CHW-1:0] act_ch;
    logic [BW-1:0]  word_cnt;
    logic [DW-1:0]  data_q;

    logic [NCH-1:0] pend, clr;
    logic           pick_any;
    logic [CHW-1:0] pick_idx;

    logic [AW-1:0]  src_a   [NCH];
    logic [AW-1:0]  dst_a   [NCH];
    logic [BW-1:0]  blen_a  [NCH];
    logic           os_a    [NCH];
    logic           last_a  [NCH];

    logic rd_fire, wr_fire, burst_end, xfer_end;

    assign rd_fire   = (state == ST_RD) && rd_rdy;
    assign wr_fire   = (state == ST_WR) && wr_rdy;
    assign burst_end = wr_fire && (word_cnt == '0);
    assign xfer_end  = burst_end && last_a[act_ch];

    dma_pend_latch #(.NCH(NCH)) u_pend (
        .clk(clk), .rst(rst), .trig(trig), .clr(clr), .pend(pend)
    );

    dma_prio_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req(pend), .any(pick_any), .idx(pick_idx)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic mine;
        assign mine  = (act_ch == CHW'(c));
        assign clr[c] = (state == ST_IDLE) && pick_any && (pick_idx == CHW'(c));

        dma_chan_regs #(.AW(AW), .BW(BW), .TW(TW)) u_regs (
            .clk        (clk),
            .rst        (rst),
            .load       (cfg_we && (cfg_ch == CHW'(c))),
            .burst_in   (cfg_burst),
            .xfer_in    (cfg_xfer),
            .oneshot_in (cfg_oneshot),
            .src_in     (cfg_src),
            .dst_in     (cfg_dst),
            .adv_src    (rd_fire && mine),
            .adv_dst    (wr_fire && mine),
            .burst_end  (burst_end && mine),
            .xfer_end   (xfer_end && mine),
            .src        (src_a[c]),
            .dst        (dst_a[c]),
            .burst_len  (blen_a[c]),
            .oneshot    (os_a[c]),
            .last_burst (last_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            act_ch   <= '0;
            word_cnt <= '0;
            data_q   <= '0;
            cpu_gnt  <= 1'b0;
            done     <= '0;
        end else begin
            cpu_gnt <= 1'b0;
            done    <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (pick_any) begin
                        act_ch   <= pick_idx;
                        word_cnt <= blen_a[pick_idx];
                        state    <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (rd_rdy) begin
                        data_q <= rd_data;
                        state  <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (wr_rdy) begin
                        cpu_gnt <= cpu_req;
                        if (word_cnt != '0) begin
                            word_cnt <= word_cnt - BW'(1);
                            state    <= ST_RD;
                        end else if (last_a[act_ch]) begin
                            done[act_ch] <= 1'b1;
                            state        <= ST_IDLE;
                        end else if (os_a[act_ch]) begin
                            word_cnt <= blen_a[act_ch];
                            state    <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req  = (state == ST_RD);
    assign rd_addr = src_a[act_ch];
    assign wr_req  = (state == ST_WR);
    assign wr_addr = dst_a[act_ch];
    assign wr_data = data_q;

    AST_GNT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt |-> $past(wr_req && wr_rdy && cpu_req)); // R9
    AST_GNT_NOT_WRITING: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt |-> !wr_req); // R9
    AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_rdy && word_cnt != '0) |=> rd_req); // R10
    AST_CHANNEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_req || wr_req) |=> $stable(act_ch)); // R4
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (done != '0) |=> (done == '0)); // R11
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done != '0) |-> $past(wr_req && wr_rdy)); // R3
endmodule

// File: tb/dma_burst_sched_bench.sv
`timescale 1ns/1ps
module dma_burst_sched_bench;
    localparam int NCH = 6;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int BW  = 8;
    localparam int TW  = 16;
    localparam int CHW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] trig = '0;
    logic           cfg_we = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic [BW-1:0]  cfg_burst = '0;
    logic [TW-1:0]  cfg_xfer = '0;
    logic           cfg_oneshot = 1'b0;
    logic [AW-1:0]  cfg_src = '0;
    logic [AW-1:0]  cfg_dst = '0;
    logic           rd_req, wr_req, cpu_gnt;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic [DW-1:0]  rd_data, wr_data;
    logic           rd_rdy = 1'b1, wr_rdy = 1'b1, cpu_req = 1'b0;
    logic [NCH-1:0] done;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return (a * 16'h0101) ^ 16'h5A3C;
    endfunction

    assign rd_data = memf(rd_addr);

    dma_burst_sched #(.NCH(NCH), .AW(AW), .DW(DW), .BW(BW), .TW(TW)) u_dma_burst_sched (
        .clk(clk), .rst(rst), .trig(trig), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_burst(cfg_burst), .cfg_xfer(cfg_xfer), .cfg_oneshot(cfg_oneshot),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rdy(rd_rdy), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_rdy(wr_rdy), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
        .done(done)
    );

    int nchk = 0, nfail = 0;
    int b_cfg[NCH], x_cfg[NCH], wcnt[NCH], wtot[NCH], dseen[NCH];
    bit os_cfg[NCH];
    logic [AW-1:0] e_src[NCH], e_dst[NCH];
    int cur_ch = 0, words_left = 0;
    int hist[64];
    int hn = 0;
    bit gnt_exp = 0, gap_exp = 0, idle_exp = 0, mon_on = 0;
    logic [NCH-1:0] done_exp = '0;
    bit rdy_rand = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model at the falling edge
    always @(negedge clk) begin
        if (!rst && mon_on) begin
            if (rd_req && wr_req) chk(0, "R1 both requests", 1, 0);
            if (gnt_exp || cpu_gnt) chk(cpu_gnt == gnt_exp, "R9 cpu_gnt", int'(cpu_gnt), int'(gnt_exp));
            if (done_exp != '0 || done != '0) chk(done == done_exp, "R11 done", int'(done), int'(done_exp));
            if (gap_exp) chk(rd_req, "R10 rd_req after mid write", int'(rd_req), 1);
            if (idle_exp) chk(!rd_req && !wr_req, "R4 arbitration cycle", int'(rd_req | wr_req), 0);
            for (int c = 0; c < NCH; c++) if (done[c]) dseen[c]++;
            gnt_exp = 0; gap_exp = 0; idle_exp = 0; done_exp = '0;
            if (wr_req && wr_rdy) begin
                int ch, total;
                ch = int'(wr_addr[15:12]);
                if (ch >= NCH) chk(0, "R8 write region", ch, 0);
                else begin
                    total = (b_cfg[ch] + 1) * (x_cfg[ch] + 1);
                    if (words_left == 0) begin
                        cur_ch = ch;
                        words_left = os_cfg[ch] ? (total - wcnt[ch]) : (b_cfg[ch] + 1);
                        if (hn < 64) hist[hn] = ch;
                        hn++;
                    end else if (ch != cur_ch) begin
                        chk(0, os_cfg[cur_ch] ? "R5 foreign write in one-shot" : "R4 foreign write in burst", ch, cur_ch);
                    end
                    chk(wr_addr == e_dst[ch], "R8 write address", int'(wr_addr), int'(e_dst[ch]));
                    chk(wr_data == memf(e_src[ch]), "R8 write data", int'(wr_data), int'(memf(e_src[ch])));
                    e_src[ch]++; e_dst[ch]++; wcnt[ch]++; wtot[ch]++;
                    words_left--;
                    gnt_exp = cpu_req;
                    if (wcnt[ch] == total) begin
                        done_exp[ch] = 1'b1;   // R3
                        wcnt[ch] = 0;
                    end
                    if (words_left > 0) gap_exp = 1; else idle_exp = 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (rdy_rand) begin
            rd_rdy  <= ($urandom % 4) != 0;
            wr_rdy  <= ($urandom % 3) != 0;
            cpu_req <= ($urandom % 2) != 0;
        end else begin
            rd_rdy <= 1'b1; wr_rdy <= 1'b1; cpu_req <= 1'b0;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic cfg(input int ch, input int b, input int x, input bit os);
        @(posedge clk); #2;
        cfg_we = 1; cfg_ch = CHW'(ch); cfg_burst = BW'(b); cfg_xfer = TW'(x);
        cfg_oneshot = os; cfg_src = AW'(16'h8000 + ch * 16'h0400 + cyc % 64);
        cfg_dst = AW'((ch << 12) + (cyc % 128));
        b_cfg[ch] = b; x_cfg[ch] = x; os_cfg[ch] = os; wcnt[ch] = 0;
        e_src[ch] = cfg_src; e_dst[ch] = cfg_dst;
        @(posedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(posedge clk); #2; trig = m;
        @(posedge clk); #2; trig = '0;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            if (rd_req || wr_req) q = 0; else q++;
        end
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int c = 0; c < NCH; c++) begin
            b_cfg[c] = 0; x_cfg[c] = 0; os_cfg[c] = 0; wcnt[c] = 0;
            wtot[c] = 0; dseen[c] = 0; e_src[c] = '0; e_dst[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rd_req && !wr_req && !cpu_gnt && done == '0, "R12 reset outputs",
            int'({rd_req, wr_req, cpu_gnt, done}), 0);
        @(posedge clk); #2; rst = 0;
        @(negedge clk);
        chk(!rd_req && !wr_req && !cpu_gnt && done == '0, "R12 after reset",
            int'({rd_req, wr_req, cpu_gnt, done}), 0);
        mon_on = 1;

        // R6: two triggers in one cycle, lower index first
        cfg(4, 1, 0, 0); cfg(1, 2, 0, 0);
        hn = 0;
        pulse(6'b010010);
        quiet();
        chk(hn == 2 && hist[0] == 1 && hist[1] == 4, "R6 priority order", hist[0] * 10 + hist[1], 14);

        // R4 R7: preemption at burst boundary, resume later
        rdy_rand = 1;
        cfg(5, 1, 2, 0); cfg(0, 0, 0, 0);
        hn = 0;
        pulse(6'b100000);
        wait (hn > 0);
        pulse(6'b100001);
        quiet();
        chk(hn == 3 && hist[0] == 5 && hist[1] == 0 && hist[2] == 5, "R7 preempt order",
            hist[0] * 100 + hist[1] * 10 + hist[2], 505);
        chk(dseen[5] == 0, "R11 no early done ch5", dseen[5], 0);
        pulse(6'b100000);
        quiet();
        chk(dseen[5] == 1 && wtot[5] == 6, "R7 resumed final burst", wtot[5], 6);

        // R11: after done, next trigger runs a full transfer again
        pulse(6'b100000); quiet(); pulse(6'b100000); quiet(); pulse(6'b100000); quiet();
        chk(dseen[5] == 2 && wtot[5] == 12, "R11 reload after done", wtot[5], 12);

        // R5: one-shot not interrupted by a higher priority trigger
        cfg(3, 1, 2, 1);
        hn = 0;
        pulse(6'b001000);
        wait (hn > 0);
        pulse(6'b000001);
        quiet();
        chk(hn == 2 && hist[0] == 3 && hist[1] == 0, "R5 one-shot then ch0", hist[0] * 10 + hist[1], 30);
        chk(dseen[3] == 1 && wtot[3] == 6, "R5 one trigger whole transfer", wtot[3], 6);

        // R2 R3: 2-word bursts, 80 bursts, one-shot = 160 words
        cfg(1, 1, 79, 1);
        wtot[1] = 0; dseen[1] = 0;
        pulse(6'b000010);
        quiet();
        chk(wtot[1] == 160, "R3 160 words", wtot[1], 160);
        chk(dseen[1] == 1, "R2 single done", dseen[1], 1);

        // R13: reconfigure mid-transfer restarts the count and pointers
        cfg(2, 1, 3, 0);
        pulse(6'b000100); quiet();
        cfg(2, 0, 1, 0);
        wtot[2] = 0; dseen[2] = 0;
        pulse(6'b000100); quiet(); pulse(6'b000100); quiet();
        chk(wtot[2] == 2 && dseen[2] == 1, "R13 reload restart", wtot[2] * 10 + dseen[2], 21);

        // Random mix
        for (int c = 0; c < NCH; c++) cfg(c, $urandom % 4, $urandom % 5, ($urandom % 3) == 0);
        for (int i = 0; i < 1500; i++) begin
            logic [NCH-1:0] m;
            @(posedge clk); #2;
            for (int c = 0; c < NCH; c++) m[c] = ($urandom % 12) == 0;
            trig = m;
        end
        @(posedge clk); #2; trig = '0;
        quiet();
        rdy_rand = 0;
        repeat (4) @(posedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule